// File: doc/BRIEF.md
# Shadow Address Region Decoder

This block sits at the front of a memory controller and sorts every bus address into one of two classes. An address below the installed memory size is an ordinary physical access. An address at or above that size is a shadow access and must never be sent straight to DRAM. There is one exception: a programmable I/O window always counts as ordinary, even when it lies above the installed memory size.

For a shadow access, the block searches a bank of remapping descriptors. Each descriptor pairs an address region with a data region. The two regions hold the same number of elements, and element i of the address region names the source of element i of the data region. The element sizes are set per descriptor, so the two regions can differ in byte size. Each descriptor also records how later translation stages should read the address-region entries.

Software sets up the block through a single-cycle register write port. The lookup port is purely combinational. It returns the shadow flag, the hit flag, the matching descriptor, the region kind, the line-aligned offset within the region, and the entry interpretation mode.

Top module: `shadow_map_decoder`

## Requirements
- R1: After reset the installed memory size is 0x4000_0000, every descriptor is disabled, the I/O window is empty and the error flag is 0.
- R2: A lookup address below the installed memory size gives lk_shadow=0 and lk_hit=0. An address at or above it, and outside the I/O window, gives lk_shadow=1.
- R3: An address inside the I/O window [io_base, io_end) gives lk_shadow=0 and lk_hit=0, even when it lies above the installed memory size. cfg_sel 5 writes io_base and cfg_sel 6 writes io_end.
- R4: A shadow address inside an enabled descriptor's address region [abase, abase + count*2^alg) gives lk_hit=1 with lk_kind=0. An address inside its data region [dbase, dbase + count*dbytes) gives lk_hit=1 with lk_kind=1. In both cases lk_idx is the descriptor number. cfg_sel 0 writes abase and cfg_sel 1 writes dbase. cfg_sel 2 writes the control word: [15:0] count, [17:16] alg, [19:18] mode, [27:20] dbytes, [31] enable.
- R5: lk_off is the address minus the base of the matched region, with the low log2(LINE_BYTES) bits cleared.
- R6: When several descriptors match, the lowest-numbered one is reported. When a descriptor's own address region and data region both match, the address region is reported.
- R7: lk_mode returns the matched descriptor's mode field: 0 means virtual addresses, 1 means array indices, 2 means physical addresses.
- R8: The following writes are rejected, leave the target unchanged and set cfg_err: a base that is not line-aligned; a control word whose dbytes is not a power of two; a control word whose mode is 3; a control word whose address-region or data-region size is not a whole number of lines.
- R9: cfg_err stays set through later accepted writes, and clears only on a write with cfg_sel 7.
- R10: A shadow address that is in no enabled descriptor's region gives lk_hit=0. A descriptor written with enable=0 never matches.
- R11: cfg_sel 4 writes the installed memory size, and the shadow boundary moves with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Register select |
| cfg_idx | input | IDXW | Descriptor number for cfg_sel 0 to 2 |
| cfg_wdata | input | AW | Write data |
| cfg_err | output | 1 | Sticky rejected-write flag |
| lk_addr | input | AW | Address to classify |
| lk_shadow | output | 1 | Address is in shadow space |
| lk_hit | output | 1 | A descriptor region matched |
| lk_idx | output | IDXW | Matching descriptor number |
| lk_kind | output | 1 | 0 address region, 1 data region |
| lk_off | output | AW | Line-aligned offset within the region |
| lk_mode | output | 2 | Entry interpretation mode of the match |

## Verification
The hardest situations to reach are ambiguous matches. In one, two descriptors cover the same address. In another, one descriptor's address region and data region coincide. A third is a descriptor region that also lies inside the I/O window or below a newly raised memory boundary. The stimulus builds these overlaps on purpose: it programs descriptor 3 to straddle descriptor 0, places descriptor 5's two regions at the same base, and then moves the I/O window and the memory size across regions that already match. Rejected writes are aimed at a descriptor already in use, so that any corruption would show up as a changed lookup result.

// File: rtl/shadow_map_decoder.sv
module shadow_map_decoder #(
  parameter int AW = 32,
  parameter int NDESC = 8,
  parameter int LINE_BYTES = 64,
  parameter logic [AW-1:0] MEM_TOP_RST = 32'h4000_0000,
  localparam int IDXW = (NDESC > 1) ? $clog2(NDESC) : 1,
  localparam int LG = $clog2(LINE_BYTES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [2:0]      cfg_sel,
  input  logic [IDXW-1:0] cfg_idx,
  input  logic [AW-1:0]   cfg_wdata,
  output logic            cfg_err,
  input  logic [AW-1:0]   lk_addr,
  output logic            lk_shadow,
  output logic            lk_hit,
  output logic [IDXW-1:0] lk_idx,
  output logic            lk_kind,
  output logic [AW-1:0]   lk_off,
  output logic [1:0]      lk_mode
);

  logic [AW-1:0] abase [NDESC];
  logic [AW-1:0] dbase [NDESC];
  logic [15:0]   cnt   [NDESC];
  logic [1:0]    alg   [NDESC];
  logic [2:0]    dlg   [NDESC];
  logic [1:0]    mode  [NDESC];
  logic [NDESC-1:0] en;
  logic [AW-1:0] mem_top, io_base, io_end;

  function automatic logic in_rng(input logic [AW-1:0] a, input logic [AW-1:0] b,
                                  input logic [AW-1:0] sz);
    return ({1'b0, a} >= {1'b0, b}) && ({1'b0, a} < ({1'b0, b} + {1'b0, sz}));
  endfunction

  // write validation
  logic [7:0]    w_db;
  logic [2:0]    w_dlg;
  logic          w_pow2;
  logic [AW-1:0] w_asz, w_dsz;
  logic          base_ok, ctrl_ok, w_bad;

  assign w_db   = cfg_wdata[27:20];
  assign w_pow2 = (w_db != 8'd0) && ((w_db & (w_db - 8'd1)) == 8'd0);

  always_comb begin
    w_dlg = 3'd0;
    for (int b = 0; b < 8; b++)
      if (w_db[b]) w_dlg = 3'(b);
  end

  assign w_asz   = AW'(cfg_wdata[15:0]) << cfg_wdata[17:16];
  assign w_dsz   = AW'(cfg_wdata[15:0]) << w_dlg;
  assign base_ok = (cfg_wdata[LG-1:0] == '0);
  assign ctrl_ok = w_pow2 && (cfg_wdata[19:18] != 2'd3) &&
                   (w_asz[LG-1:0] == '0) && (w_dsz[LG-1:0] == '0);
  assign w_bad   = cfg_we && (((cfg_sel == 3'd0 || cfg_sel == 3'd1) && !base_ok) ||
                              (cfg_sel == 3'd2 && !ctrl_ok));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NDESC; i++) begin
        abase[i] <= '0;
        dbase[i] <= '0;
        cnt[i]   <= '0;
        alg[i]   <= '0;
        dlg[i]   <= '0;
        mode[i]  <= '0;
      end
      en      <= '0;
      mem_top <= MEM_TOP_RST;
      io_base <= '0;
      io_end  <= '0;
      cfg_err <= 1'b0;
    end else if (cfg_we) begin
      if (w_bad) cfg_err <= 1'b1;
      else begin
        case (cfg_sel)
          3'd0: abase[cfg_idx] <= cfg_wdata;
          3'd1: dbase[cfg_idx] <= cfg_wdata;
          3'd2: begin
            cnt[cfg_idx]  <= cfg_wdata[15:0];
            alg[cfg_idx]  <= cfg_wdata[17:16];
            mode[cfg_idx] <= cfg_wdata[19:18];
            dlg[cfg_idx]  <= w_dlg;
            en[cfg_idx]   <= cfg_wdata[31];
          end
          3'd4: mem_top <= cfg_wdata;
          3'd5: io_base <= cfg_wdata;
          3'd6: io_end  <= cfg_wdata;
          3'd7: cfg_err <= 1'b0;
          default: ;
        endcase
      end
    end
  end

  // lookup
  logic in_io;
  assign in_io     = (lk_addr >= io_base) && (lk_addr < io_end);
  assign lk_shadow = (lk_addr >= mem_top) && !in_io;

  logic [AW-1:0] raw_off;
  logic          any;

  always_comb begin
    any     = 1'b0;
    lk_idx  = '0;
    lk_kind = 1'b0;
    lk_mode = 2'd0;
    raw_off = '0;
    for (int i = NDESC - 1; i >= 0; i--) begin
      if (en[i] && in_rng(lk_addr, dbase[i], AW'(cnt[i]) << dlg[i])) begin
        any = 1'b1; lk_idx = IDXW'(i); lk_kind = 1'b1; lk_mode = mode[i];
        raw_off = lk_addr - dbase[i];
      end
      if (en[i] && in_rng(lk_addr, abase[i], AW'(cnt[i]) << alg[i])) begin
        any = 1'b1; lk_idx = IDXW'(i); lk_kind = 1'b0; lk_mode = mode[i];
        raw_off = lk_addr - abase[i];
      end
    end
  end

  assign lk_hit = lk_shadow && any;
  assign lk_off = {raw_off[AW-1:LG], {LG{1'b0}}};

  // R4
  hit_needs_shadow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> lk_shadow);
  // R5
  off_line_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_off[LG-1:0] == '0);
  // R3
  io_never_shadow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_addr >= io_base && lk_addr < io_end) |-> !lk_shadow && !lk_hit);
  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_err && !(cfg_we && cfg_sel == 3'd7)) |=> cfg_err);
  // R8
  err_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_err) |-> $past(cfg_we));
  // R2
  below_top_normal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_addr < mem_top) |-> !lk_shadow);

endmodule

// File: tb/shadow_map_decoder_tb.sv
module shadow_map_decoder_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_sel = '0;
  logic [2:0] cfg_idx = '0;
  logic [31:0] cfg_wdata = '0;
  logic cfg_err;
  logic [31:0] lk_addr = '0;
  logic lk_shadow, lk_hit, lk_kind;
  logic [2:0] lk_idx;
  logic [31:0] lk_off;
  logic [1:0] lk_mode;
  int errors = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shadow_map_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .cfg_err(cfg_err), .lk_addr(lk_addr), .lk_shadow(lk_shadow),
    .lk_hit(lk_hit), .lk_idx(lk_idx), .lk_kind(lk_kind), .lk_off(lk_off), .lk_mode(lk_mode));

  task automatic wr(input logic [2:0] sel, input logic [2:0] idx, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_idx = idx; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic chk_err(input logic exp, input string req);
    checks++;
    if (cfg_err !== exp) begin
      errors++;
      $display("FAIL %s cfg_err act=%0b exp=%0b", req, cfg_err, exp);
    end
  endtask

  task automatic look(input logic [31:0] a, input logic sh, input logic hit,
                      input logic [2:0] idx, input logic kind, input logic [31:0] off,
                      input logic [1:0] md, input string req);
    lk_addr = a;
    #1;
    checks++;
    if (lk_shadow !== sh || lk_hit !== hit ||
        (hit && (lk_idx !== idx || lk_kind !== kind || lk_off !== off || lk_mode !== md))) begin
      errors++;
      $display("FAIL %s addr=%h act sh=%0b hit=%0b idx=%0d kind=%0b off=%h mode=%0d exp sh=%0b hit=%0b idx=%0d kind=%0b off=%h mode=%0d",
               req, a, lk_shadow, lk_hit, lk_idx, lk_kind, lk_off, lk_mode,
               sh, hit, idx, kind, off, md);
    end
  endtask

  task automatic t_reset;
    chk_err(1'b0, "R1");
    look(32'h3FFF_FFFF, 1'b0, 1'b0, 0, 0, 0, 0, "R1");
    look(32'h4000_0000, 1'b1, 1'b0, 0, 0, 0, 0, "R1");
    look(32'h8000_0000, 1'b1, 1'b0, 0, 0, 0, 0, "R1");
  endtask

  task automatic t_basic;
    wr(3'd0, 3'd0, 32'h8000_0000);
    wr(3'd1, 3'd0, 32'h8001_0000);
    wr(3'd2, 3'd0, 32'h8046_0020);
    chk_err(1'b0, "R4");
    look(32'h8000_0044, 1'b1, 1'b1, 0, 0, 32'h40, 2'd1, "R4");
    look(32'h8000_0000, 1'b1, 1'b1, 0, 0, 32'h0, 2'd1, "R5");
    look(32'h8000_0080, 1'b1, 1'b0, 0, 0, 0, 0, "R10");
    look(32'h8001_007F, 1'b1, 1'b1, 0, 1, 32'h40, 2'd1, "R4");
    look(32'h8001_0080, 1'b1, 1'b0, 0, 0, 0, 0, "R10");
    look(32'h1000_0000, 1'b0, 1'b0, 0, 0, 0, 0, "R2");
  endtask

  task automatic t_priority;
    wr(3'd0, 3'd3, 32'h8000_0040);
    wr(3'd1, 3'd3, 32'h9000_0000);
    wr(3'd2, 3'd3, 32'h810B_0010);
    look(32'h8000_0050, 1'b1, 1'b1, 0, 0, 32'h40, 2'd1, "R6");
    look(32'h8000_0090, 1'b1, 1'b1, 3, 0, 32'h40, 2'd2, "R6");
    look(32'h9000_00FF, 1'b1, 1'b1, 3, 1, 32'hC0, 2'd2, "R7");
    look(32'h9000_0100, 1'b1, 1'b0, 0, 0, 0, 0, "R4");
    wr(3'd0, 3'd5, 32'hA000_0000);
    wr(3'd1, 3'd5, 32'hA000_0000);
    wr(3'd2, 3'd5, 32'h8042_0010);
    look(32'hA000_0010, 1'b1, 1'b1, 5, 0, 32'h0, 2'd0, "R6");
    look(32'hA000_0040, 1'b1, 1'b0, 0, 0, 0, 0, "R4");
  endtask

  task automatic t_reject;
    wr(3'd0, 3'd0, 32'h8000_0004);
    chk_err(1'b1, "R8");
    look(32'h8000_0044, 1'b1, 1'b1, 0, 0, 32'h40, 2'd1, "R8");
    wr(3'd7, 3'd0, 32'h0);
    chk_err(1'b0, "R9");
    wr(3'd2, 3'd0, 32'h8032_0020);
    chk_err(1'b1, "R8");
    look(32'h8001_007F, 1'b1, 1'b1, 0, 1, 32'h40, 2'd1, "R8");
    wr(3'd1, 3'd6, 32'hB000_0000);
    chk_err(1'b1, "R9");
    wr(3'd7, 3'd0, 32'h0);
    wr(3'd2, 3'd0, 32'h8042_0008);
    chk_err(1'b1, "R8");
    look(32'h8000_0044, 1'b1, 1'b1, 0, 0, 32'h40, 2'd1, "R8");
    wr(3'd7, 3'd0, 32'h0);
    wr(3'd2, 3'd0, 32'h804E_0020);
    chk_err(1'b1, "R8");
    look(32'h8000_0044, 1'b1, 1'b1, 0, 0, 32'h40, 2'd1, "R8");
    wr(3'd7, 3'd0, 32'h0);
    chk_err(1'b0, "R9");
  endtask

  task automatic t_disable;
    wr(3'd2, 3'd5, 32'h0042_0010);
    chk_err(1'b0, "R10");
    look(32'hA000_0010, 1'b1, 1'b0, 0, 0, 0, 0, "R10");
  endtask

  task automatic t_io_top;
    wr(3'd5, 3'd0, 32'h8000_0000);
    wr(3'd6, 3'd0, 32'h8000_0040);
    look(32'h8000_0010, 1'b0, 1'b0, 0, 0, 0, 0, "R3");
    look(32'h8000_0044, 1'b1, 1'b1, 0, 0, 32'h40, 2'd1, "R3");
    wr(3'd4, 3'd0, 32'h9000_0000);
    look(32'h8001_0000, 1'b0, 1'b0, 0, 0, 0, 0, "R11");
    look(32'h9000_00FF, 1'b1, 1'b1, 3, 1, 32'hC0, 2'd2, "R11");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_priority();
    t_reject();
    t_disable();
    t_io_top();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule